// File: doc/BRIEF.md
# Block Cipher Host Front-End

This block sits between a register bus and a 128-bit block cipher core. Software (or a DMA engine) talks to it through five 32-bit registers: a status register that starts and stops processing, an input data port that feeds an 8-word input FIFO, an output data port that drains an 8-word output FIFO, an interrupt cause register, and a configuration register that picks direction, chaining mode and which header words are present.

Once started, the front-end parses the words arriving in the input FIFO. The first word is an optional block count. Four optional key words come next, then four optional initialization-vector words. Every word after that is payload. Payload is grouped into 128-bit blocks and handed to the core over a valid/ready request port. Results come back on a response strobe and are split into four words in the output FIFO. In CBC mode the front-end does the chaining XOR itself. When a counted ECB job decrypts, or when key replay is requested, the stored key follows the last block into the output FIFO. A completion cause is raised when the counted blocks are done. FIFO misuse raises error causes. The interrupt line is the OR of the causes, gated by an enable bit.

The cipher rounds are not part of this block. A placeholder core XORs each block with the key. It obeys a clock-rate divider, so throughput can be set while results stay exact.

Top module: `bcf_host_frontend`

## Requirements
- R1: After reset, the status register reads 0x20 (only the input-space bit 5 high), the cause and configuration registers read zero, and `irq` is low.
- R2: With configuration count-defined, new key and ECB, the parser takes its words in this order: a block-count word, four key words, then payload. A 128-bit value is packed most-significant word first (first word in bits 127:96). Each output word i equals payload word i XOR key word i.
- R3: With configuration bit 3 (key reuse) set, no key words are expected, and the key stored by the previous job is used.
- R4: With configuration bit 4 (undefined count) set, no count word is expected, blocks are processed for as long as payload arrives, and cause bit 0 never sets.
- R5: With configuration bits 6:5 = 01 (CBC), four IV words follow the key. Encrypt sends plaintext XOR chain to the core and chains on the core output. Decrypt XORs the chain into the core output and chains on the incoming ciphertext. Modes 10 and 11 also consume four IV words.
- R6: In ECB mode with a defined count, when configuration bit 0 (decrypt) or bit 2 (key replay) is set, the four key words are pushed to the output FIFO after the last data block, most-significant word first. Otherwise nothing follows the data.
- R7: Cause bit 0 sets once the counted blocks and any replay words have been pushed. Cause bits stay set until written with zero. `irq` is high exactly when status bit 1 is set and some cause bit is set.
- R8: A write to input data (offset 0x04) while the input FIFO holds 8 words sets cause bit 1 and discards the word. Status bit 5 reads low while the FIFO is full.
- R9: A read of output data (offset 0x08) while the output FIFO is empty returns zero and sets cause bit 2. Status bit 4 reads high while the output FIFO holds a word.
- R10: Clearing status bit 0 aborts the job and returns the parser to expect the count word. Words already in either FIFO are kept and are parsed after the next start.
- R11: Status bits 3:2 divide the core rate by 1, 2, 4 or 8. Results are identical at every rate.
- R12: A defined block count of zero finishes right after the header. Cause bit 0 sets, and the replay words of R6 are still produced when R6 applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops output data) |
| bus_addr | input | 5 | Byte offset: 0x00 status, 0x04 input data, 0x08 output data, 0x0C cause, 0x10 configuration |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the header parser's skip rules. If the count, key or IV stage were not skipped correctly, every later word would shift by a position and all outputs would be wrong. CBC chaining is checked in both directions by decrypting the bench's own ciphertext; a chain updated from the wrong side would give back garbage on the second block. The overflow test fills the FIFO while the engine is stopped and offers a poison word as the ninth write, so a design that accepted it would corrupt the payload. An abort after a half-written header checks that a stale parser position would take a count word as a key. A zero count checks that completion does not wait for a block that never comes.

// File: rtl/bcf_pkg.sv
package bcf_pkg;
    localparam int WORD_W = 32;
    localparam int BLK_W  = 128;
    localparam int WORDS  = BLK_W / WORD_W;

    // byte offsets of the register map
    localparam logic [4:0] OFS_STATUS = 5'h00;
    localparam logic [4:0] OFS_IN     = 5'h04;
    localparam logic [4:0] OFS_OUT    = 5'h08;
    localparam logic [4:0] OFS_CAUSE  = 5'h0C;
    localparam logic [4:0] OFS_CFG    = 5'h10;

    typedef enum logic [3:0] {
        P_COUNT, P_KEY, P_IV, P_DATA, P_CORE, P_WAIT, P_PUSH, P_TAIL, P_DONE
    } parse_st_t;

    typedef enum logic [1:0] {
        M_ECB = 2'b00, M_CBC = 2'b01, M_CFB = 2'b10, M_OFB = 2'b11
    } chain_mode_t;
endpackage

// File: rtl/bcf_fifo.sv
// Synchronous first-word-fall-through FIFO.
// Assumes DEPTH is a power of two; push when full and pop when empty are ignored.
module bcf_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 rdata,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign empty   = (level == '0);
    assign full    = (level == LW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    // storage write
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // pointer and level bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            level <= level + LW'(do_push) - LW'(do_pop);
        end
    end
endmodule

// File: rtl/bcf_core_stub.sv
// Placeholder cipher core: result = block XOR key, one cycle after acceptance.
// Accepts a request only on a rate tick derived from the divider select.
// Assumes the requester waits for the response before the next request.
module bcf_core_stub
    import bcf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       rate_sel,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [BLK_W-1:0] req_data,
    input  logic [BLK_W-1:0] req_key,
    output logic             rsp_valid,
    output logic [BLK_W-1:0] rsp_data
);
    logic [2:0] div_cnt;
    logic [2:0] div_mask;

    assign div_mask  = 3'((4'd1 << rate_sel) - 4'd1);
    assign req_ready = ((div_cnt & div_mask) == 3'd0);

    // free-running rate counter
    always_ff @(posedge clk) begin
        if (!rst_n) div_cnt <= '0;
        else        div_cnt <= div_cnt + 3'd1;
    end

    // one-cycle transform
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= req_valid && req_ready;
            if (req_valid && req_ready) rsp_data <= req_data ^ req_key;
        end
    end
endmodule

// File: rtl/bcf_host_frontend.sv
// Register front-end for a 128-bit block cipher core.
// Parses count/key/IV header words from the input FIFO, runs payload blocks
// through the core with optional CBC chaining and fills the output FIFO.
// Assumes configuration is not changed while status bit 0 is set.
module bcf_host_frontend
    import bcf_pkg::*;
#(
    parameter int FIFO_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    localparam int LW = $clog2(FIFO_DEPTH+1);
    localparam int IW = $clog2(WORDS);
    localparam logic [IW-1:0] LAST = IW'(WORDS-1);

    // control registers
    logic        start_q, ie_q;
    logic [1:0]  rate_q;
    logic [2:0]  cause_q;
    logic [6:0]  cfg_q;

    // FIFO wiring
    logic              in_push, in_pop, in_empty, in_full;
    logic [WORD_W-1:0] in_head;
    logic [LW-1:0]     in_level;
    logic              out_push, out_pop, out_empty, out_full;
    logic [WORD_W-1:0] out_head, out_wdata;
    logic [LW-1:0]     out_level;

    // parser state
    parse_st_t         state;
    logic [IW-1:0]     idx;
    logic [WORD_W-1:0] count_q, blocks_done;
    logic [BLK_W-1:0]  key_q, chain_q, blk_q, res_q;

    // core port
    logic              core_valid, core_ready, rsp_valid;
    logic [BLK_W-1:0]  core_data, rsp_data;

    // decoded configuration and events
    logic        cfg_dec, cfg_rpk, cfg_rk, cfg_uc;
    chain_mode_t mode;
    logic        is_ecb, is_cbc, cnt_reached, tail_needed;
    logic        wr_status, wr_in, wr_cause, wr_cfg, rd_out;
    logic        ovf_evt, udf_evt, done_evt;
    logic        parser_idle;

    assign cfg_dec = cfg_q[0];
    assign cfg_rpk = cfg_q[2];
    assign cfg_rk  = cfg_q[3];
    assign cfg_uc  = cfg_q[4];
    assign mode    = chain_mode_t'(cfg_q[6:5]);
    assign is_ecb  = (mode == M_ECB);
    assign is_cbc  = (mode == M_CBC);

    assign cnt_reached = !cfg_uc && (blocks_done == count_q);
    assign tail_needed = is_ecb && !cfg_uc && (cfg_dec || cfg_rpk);
    assign parser_idle = (state == P_COUNT);

    assign wr_status = bus_wr && (bus_addr == OFS_STATUS);
    assign wr_in     = bus_wr && (bus_addr == OFS_IN);
    assign wr_cause  = bus_wr && (bus_addr == OFS_CAUSE);
    assign wr_cfg    = bus_wr && (bus_addr == OFS_CFG);
    assign rd_out    = bus_rd && (bus_addr == OFS_OUT);

    assign ovf_evt  = wr_in && in_full;
    assign udf_evt  = rd_out && out_empty;
    assign done_evt = start_q &&
                      ((state == P_DATA && cnt_reached && !tail_needed) ||
                       (state == P_TAIL && !out_full && idx == LAST));

    assign in_push = wr_in && !in_full;
    assign out_pop = rd_out && !out_empty;

    // input FIFO pops while a header or payload word is awaited
    always_comb begin
        in_pop = 1'b0;
        if (start_q && !in_empty) begin
            unique case (state)
                P_COUNT: in_pop = !cfg_uc;
                P_KEY:   in_pop = !cfg_rk;
                P_IV:    in_pop = !is_ecb;
                P_DATA:  in_pop = !cnt_reached;
                default: in_pop = 1'b0;
            endcase
        end
    end

    // output FIFO takes result words, then replay key words
    assign out_push  = start_q && !out_full && (state == P_PUSH || state == P_TAIL);
    assign out_wdata = (state == P_TAIL) ? key_q[BLK_W-1-WORD_W*idx -: WORD_W]
                                         : res_q[BLK_W-1-WORD_W*idx -: WORD_W];

    // core request, with encrypt-side chaining
    assign core_valid = start_q && (state == P_CORE);
    assign core_data  = (is_cbc && !cfg_dec) ? (blk_q ^ chain_q) : blk_q;

    bcf_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_in_fifo (
        .clk(clk), .rst_n(rst_n), .push(in_push), .wdata(bus_wdata),
        .pop(in_pop), .rdata(in_head), .empty(in_empty), .full(in_full),
        .level(in_level)
    );

    bcf_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_out_fifo (
        .clk(clk), .rst_n(rst_n), .push(out_push), .wdata(out_wdata),
        .pop(out_pop), .rdata(out_head), .empty(out_empty), .full(out_full),
        .level(out_level)
    );

    bcf_core_stub u_core (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_q),
        .req_valid(core_valid), .req_ready(core_ready),
        .req_data(core_data), .req_key(key_q),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    // status and configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            ie_q    <= 1'b0;
            rate_q  <= 2'd0;
            cfg_q   <= '0;
        end else begin
            if (wr_status) begin
                start_q <= bus_wdata[0];
                ie_q    <= bus_wdata[1];
                rate_q  <= bus_wdata[3:2];
            end
            if (wr_cfg) cfg_q <= bus_wdata[6:0];
        end
    end

    // sticky causes: a written zero clears, events set
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else cause_q <= (wr_cause ? (cause_q & bus_wdata[2:0]) : cause_q)
                        | {udf_evt, ovf_evt, done_evt};
    end

    // header parser and block sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= P_COUNT;
            idx         <= '0;
            blocks_done <= '0;
            count_q     <= '0;
            key_q       <= '0;
            chain_q     <= '0;
            blk_q       <= '0;
            res_q       <= '0;
        end else if (!start_q) begin
            state       <= P_COUNT;
            idx         <= '0;
            blocks_done <= '0;
        end else begin
            unique case (state)
                P_COUNT: begin
                    if (cfg_uc) state <= P_KEY;
                    else if (!in_empty) begin
                        count_q <= in_head;
                        state   <= P_KEY;
                    end
                end
                P_KEY: begin
                    if (cfg_rk) state <= P_IV;
                    else if (!in_empty) begin
                        key_q[BLK_W-1-WORD_W*idx -: WORD_W] <= in_head;
                        idx <= idx + 1'b1;
                        if (idx == LAST) state <= P_IV;
                    end
                end
                P_IV: begin
                    if (is_ecb) state <= P_DATA;
                    else if (!in_empty) begin
                        chain_q[BLK_W-1-WORD_W*idx -: WORD_W] <= in_head;
                        idx <= idx + 1'b1;
                        if (idx == LAST) state <= P_DATA;
                    end
                end
                P_DATA: begin
                    if (cnt_reached) state <= tail_needed ? P_TAIL : P_DONE;
                    else if (!in_empty) begin
                        blk_q[BLK_W-1-WORD_W*idx -: WORD_W] <= in_head;
                        idx <= idx + 1'b1;
                        if (idx == LAST) state <= P_CORE;
                    end
                end
                P_CORE: if (core_ready) state <= P_WAIT;
                P_WAIT: begin
                    if (rsp_valid) begin
                        res_q <= (is_cbc && cfg_dec) ? (rsp_data ^ chain_q) : rsp_data;
                        if (is_cbc) chain_q <= cfg_dec ? blk_q : rsp_data;
                        state <= P_PUSH;
                    end
                end
                P_PUSH: begin
                    if (!out_full) begin
                        idx <= idx + 1'b1;
                        if (idx == LAST) begin
                            blocks_done <= blocks_done + 1'b1;
                            state       <= P_DATA;
                        end
                    end
                end
                P_TAIL: begin
                    if (!out_full) begin
                        idx <= idx + 1'b1;
                        if (idx == LAST) state <= P_DONE;
                    end
                end
                default: state <= P_DONE;
            endcase
        end
    end

    // register read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                OFS_STATUS: bus_rdata = {26'd0, !in_full, !out_empty, rate_q, ie_q, start_q};
                OFS_OUT:    bus_rdata = out_empty ? '0 : out_head;
                OFS_CAUSE:  bus_rdata = {29'd0, cause_q};
                OFS_CFG:    bus_rdata = {25'd0, cfg_q};
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign irq = ie_q && (cause_q != '0);
endmodule

// File: rtl/bcf_host_frontend_chk.sv
// Property checker for the front-end, attached by bind below.
module bcf_host_frontend_chk
    import bcf_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int LW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [4:0]    bus_addr,
    input logic [31:0]   bus_rdata,
    input logic          irq,
    input logic          ie_q,
    input logic          start_q,
    input logic [2:0]    cause_q,
    input logic          in_full,
    input logic          out_empty,
    input logic [LW-1:0] in_level,
    input logic          parser_idle
);
    // R8: a write into a full input FIFO flags overflow
    a_r8_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_IN && in_full) |=> cause_q[1]);

    // R8: input FIFO never exceeds its depth
    a_r8_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        in_level <= LW'(FIFO_DEPTH));

    // R9: an empty read flags underflow and returns zero
    a_r9_underflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_OUT && out_empty) |=> cause_q[2]);
    a_r9_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_OUT && out_empty) |-> bus_rdata == 32'd0);

    // R7: completion cause is sticky until the cause register is written
    a_r7_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q[0] && !(bus_wr && bus_addr == OFS_CAUSE)) |=> cause_q[0]);

    // R7: no interrupt while interrupts are disabled
    a_r7_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_q |-> !irq);

    // R10: a stopped engine returns the parser to the count stage
    a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !start_q |=> parser_idle);
endmodule

bind bcf_host_frontend bcf_host_frontend_chk #(
    .FIFO_DEPTH(FIFO_DEPTH), .LW($clog2(FIFO_DEPTH+1))
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq(irq), .ie_q(ie_q),
    .start_q(start_q), .cause_q(cause_q), .in_full(in_full),
    .out_empty(out_empty), .in_level(in_level), .parser_idle(parser_idle)
);

// File: tb/tb_bcf_host_frontend.sv
module tb_bcf_host_frontend;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    localparam logic [4:0] A_ST = 5'h00, A_IN = 5'h04, A_OUT = 5'h08,
                           A_CA = 5'h0C, A_CF = 5'h10;

    always #2.5 clk = ~clk;   // 200 MHz

    bcf_host_frontend dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic push_word(input logic [31:0] w);
        logic [31:0] s;
        for (int i = 0; i < 500; i++) begin
            bus_read(A_ST, s);
            if (s[5]) break;
        end
        bus_write(A_IN, w);
    endtask

    task automatic push_blk(input logic [127:0] b);
        for (int i = 0; i < 4; i++) push_word(b[127-32*i -: 32]);
    endtask

    task automatic pop_blk(output logic [127:0] b);
        logic [31:0] s, w;
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 500; j++) begin
                bus_read(A_ST, s);
                if (s[4]) break;
            end
            bus_read(A_OUT, w);
            b[127-32*i -: 32] = w;
        end
    endtask

    task automatic wait_ready(output logic [31:0] c);
        for (int i = 0; i < 200; i++) begin
            bus_read(A_CA, c);
            if (c[0]) break;
        end
    endtask

    task automatic finish_job();
        bus_write(A_ST, 32'h0);
        bus_write(A_CA, 32'h0);
    endtask

    localparam logic [127:0] K1 = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
    localparam logic [127:0] K2 = 128'h13579bdf_2468ace0_fedcba98_76543210;
    localparam logic [127:0] D0 = 128'h00112233_44556677_8899aabb_ccddeeff;
    localparam logic [127:0] D1 = 128'hdeadbeef_cafef00d_01234567_89abcdef;
    localparam logic [127:0] IV = 128'ha5a5a5a5_5a5a5a5a_3c3c3c3c_c3c3c3c3;

    task automatic t_reset();
        logic [31:0] v;
        bus_read(A_ST, v); check("R1 status", v, 32'h20);
        bus_read(A_CA, v); check("R1 cause", v, 0);
        bus_read(A_CF, v); check("R1 cfg", v, 0);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_ecb_basic();
        logic [127:0] r; logic [31:0] v;
        bus_write(A_CF, 32'h00);
        bus_write(A_ST, 32'h3);
        push_word(32'd2); push_blk(K1); push_blk(D0); push_blk(D1);
        pop_blk(r); check("R2 ecb blk0", r, D0 ^ K1);
        pop_blk(r); check("R2 ecb blk1", r, D1 ^ K1);
        wait_ready(v); check("R7 ready cause", v[0], 1);
        check("R7 irq raised", irq, 1);
        bus_read(A_ST, v); check("R6 no tail on encrypt", v[4], 0);
        bus_write(A_CA, 32'h0);
        bus_read(A_CA, v); check("R7 cause cleared", v, 0);
        check("R7 irq dropped", irq, 0);
        finish_job();
    endtask

    task automatic t_tail(input logic [31:0] cfg, input string tag);
        logic [127:0] r; logic [31:0] v;
        bus_write(A_CF, cfg);
        bus_write(A_ST, 32'h1);
        push_word(32'd1); push_blk(K2); push_blk(D0);
        pop_blk(r); check({tag, " data"}, r, D0 ^ K2);
        pop_blk(r); check({tag, " replay key"}, r, K2);
        wait_ready(v); check("R7 ready after tail", v[0], 1);
        check("R7 irq masked when disabled", irq, 0);
        finish_job();
    endtask

    task automatic t_reuse_key();
        logic [127:0] r;
        bus_write(A_CF, 32'h08);
        bus_write(A_ST, 32'h1);
        push_word(32'd1); push_blk(D1);
        pop_blk(r); check("R3 reused key", r, D1 ^ K2);
        finish_job();
    endtask

    task automatic t_undefined();
        logic [127:0] r; logic [31:0] v;
        bus_write(A_CF, 32'h10);
        bus_write(A_ST, 32'h1);
        push_blk(K1); push_blk(D0); push_blk(D1);
        pop_blk(r); check("R4 uncounted blk0", r, D0 ^ K1);
        pop_blk(r); check("R4 uncounted blk1", r, D1 ^ K1);
        repeat (40) @(negedge clk);
        bus_read(A_CA, v); check("R4 no ready", v[0], 0);
        finish_job();
    endtask

    task automatic t_cbc();
        logic [127:0] r, c0, c1;
        c0 = D0 ^ IV ^ K1;
        c1 = D1 ^ c0 ^ K1;
        bus_write(A_CF, 32'h20);
        bus_write(A_ST, 32'h1);
        push_word(32'd2); push_blk(K1); push_blk(IV); push_blk(D0); push_blk(D1);
        pop_blk(r); check("R5 cbc enc blk0", r, c0);
        pop_blk(r); check("R5 cbc enc blk1", r, c1);
        finish_job();
        bus_write(A_CF, 32'h21);
        bus_write(A_ST, 32'h1);
        push_word(32'd2); push_blk(K1); push_blk(IV); push_blk(c0); push_blk(c1);
        pop_blk(r); check("R5 cbc dec blk0", r, D0);
        pop_blk(r); check("R5 cbc dec blk1", r, D1);
        finish_job();
    endtask

    task automatic t_overflow();
        logic [127:0] r; logic [31:0] v;
        bus_write(A_CF, 32'h00);
        bus_write(A_IN, 32'd1);
        for (int i = 0; i < 4; i++) bus_write(A_IN, K1[127-32*i -: 32]);
        for (int i = 0; i < 3; i++) bus_write(A_IN, D0[127-32*i -: 32]);
        bus_read(A_ST, v); check("R8 full clears space bit", v[5], 0);
        bus_write(A_IN, 32'hbad0bad0);
        bus_read(A_CA, v); check("R8 overflow cause", v[1], 1);
        bus_write(A_CA, 32'h0);
        bus_write(A_ST, 32'h1);
        push_word(D0[31:0]);
        pop_blk(r); check("R8 poison word discarded / R10 fifo kept", r, D0 ^ K1);
        finish_job();
    endtask

    task automatic t_underflow();
        logic [31:0] v;
        bus_read(A_OUT, v); check("R9 empty read zero", v, 0);
        bus_read(A_CA, v); check("R9 underflow cause", v[2], 1);
        bus_write(A_CA, 32'h0);
    endtask

    task automatic t_abort();
        logic [127:0] r;
        bus_write(A_CF, 32'h00);
        bus_write(A_ST, 32'h1);
        push_word(32'd1); push_word(32'h11111111);
        repeat (10) @(negedge clk);
        bus_write(A_ST, 32'h0);
        bus_write(A_ST, 32'h1);
        push_word(32'd1); push_blk(K2); push_blk(D1);
        pop_blk(r); check("R10 restart parses count", r, D1 ^ K2);
        finish_job();
    endtask

    task automatic t_divider();
        logic [127:0] r; logic [31:0] v;
        bus_write(A_CF, 32'h00);
        bus_write(A_ST, 32'hD);
        bus_read(A_ST, v); check("R11 rate readback", v[3:2], 2'b11);
        push_word(32'd1); push_blk(K1); push_blk(D1);
        pop_blk(r); check("R11 divided rate result", r, D1 ^ K1);
        finish_job();
    endtask

    task automatic t_zero_count();
        logic [127:0] r; logic [31:0] v;
        bus_write(A_CF, 32'h01);
        bus_write(A_ST, 32'h1);
        push_word(32'd0); push_blk(K1);
        pop_blk(r); check("R12 zero count replay", r, K1);
        wait_ready(v); check("R12 zero count ready", v[0], 1);
        finish_job();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ecb_basic();
        t_tail(32'h01, "R6 ecb decrypt");
        t_tail(32'h04, "R6 ecb replay");
        t_reuse_key();
        t_undefined();
        t_cbc();
        t_overflow();
        t_underflow();
        t_abort();
        t_divider();
        t_zero_count();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule